// File: doc/BRIEF.md
# Block Access Permission Checker

This block decides, for each pending serial memory access, whether the byte may be read or written. The memory behind it is a main array split into equal blocks, with each block split into equal pages. Next to the main array sit a protection page and an identification page. The surrounding interface logic raises one event for each access that needs a decision. One kind of event is the address byte of a write command, which carries the target. The other is the device-select byte of a read, which has no usable target of its own.

One clock after the event, the block returns three things. The first is a permit flag. The second is the bus slot at which the access must be refused: the data byte of a write, or the read select byte. The third is a flag telling the write sequencer whether a write cycle should follow.

Permissions work at two levels. Each block has a 2-bit field. Block 0 also has one write-enable bit per page. A global write-protect pin overrides both levels and refuses every write. The protection-page field governs the upper protection-page bytes and the whole identification page. A read is always judged against the target latched by the most recent write command. The stored fields come in as plain inputs. Keeping them is left to the surrounding logic.

Top module: `acc_perm_chk`

## Requirements
- R1: A decision appears on the outputs in the clock after `evt_valid` is sampled high. `dec_valid` is high for exactly that one cycle. `dec_permit`, `dec_nack_pt` and `dec_wr_go` keep their values until the next decision.
- R2: A main-array read is permitted when bit 1 of the target block's field is 1 (encodings 10 and 11). With encodings 00 and 01 it is refused with `dec_nack_pt` = 2 (read select byte).
- R3: A main-array write is permitted only when the target block's field is 11. Blocks 1 and above ignore the page write-enable bits. A refused write gives `dec_permit` = 0, `dec_nack_pt` = 1 (data byte) and `dec_wr_go` = 0.
- R4: In block 0, bit k of `b0_page_wen` governs bytes 16k to 16k+15 (address bits [6:4] select the page). A write there is permitted only when that bit is 1 and block 0's field is 11.
- R5: With `wp` high, every write is refused with `dec_nack_pt` = 1. This covers the main array, the protection page and the identification page. Reads are unaffected.
- R6: A read is checked against the space and address latched by the most recent write-command event. The bits on the read select byte play no part. After reset the latched target is main-array address 0.
- R7: Protection-page bytes 0 to 8 (`tgt_side` = 1, offset `tgt_addr[4:0]` 0 to 8) are always readable. With `wp` low they are writable with `dec_wr_go` = 1, whatever the value of `side_field`.
- R8: Protection-page bytes 9 to 15 and identification-page bytes (offsets 16 to 31) follow `side_field`, using the same encoding as R2 and R3.
- R9: Offsets 14 and 15 are read-only stored bytes. A write to them that R5 and R8 would allow is permitted (acknowledged), but `dec_wr_go` = 0.
- R10: During and right after reset, `dec_valid`, `dec_permit`, `dec_nack_pt` and `dec_wr_go` are all 0.
- R11: A permitted main-array write gives `dec_permit` = 1, `dec_nack_pt` = 0 and `dec_wr_go` = 1. A permitted read gives `dec_permit` = 1, `dec_nack_pt` = 0 and `dec_wr_go` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | A decision is requested this cycle |
| evt_read | input | 1 | 1 = read select byte, 0 = write-command address byte |
| tgt_side | input | 1 | Target space for write events: 0 = main array, 1 = protection/ID pages |
| tgt_addr | input | ADDR_W (10) | Main: block, page and byte address; side: offset in bits [4:0] |
| wp | input | 1 | Global write protect, active high |
| blk_fields | input | 2*NUM_BLOCKS (16) | Field of block k in bits [2k+1:2k] |
| side_field | input | 2 | Field governing protection-page bytes 9 to 15 and the ID page |
| b0_page_wen | input | PG_PER_BLK (8) | Block 0 page write enables, bit k = page k |
| dec_valid | output | 1 | One-cycle pulse marking a fresh decision |
| dec_permit | output | 1 | Access permitted |
| dec_nack_pt | output | 2 | Refusal slot: 0 none, 1 data byte, 2 read select byte |
| dec_wr_go | output | 1 | A write cycle should follow this access |

## Verification
The bench builds the block with its default parameters: eight blocks of 128 bytes and eight 16-byte pages per block. With this geometry, loops can reach every page of block 0 and every field encoding on a chosen block. Directed sequences cover the boundary offsets of the protection page (8/9, 13/14/15, 16) and the identification page. They also cover writes under the protect pin. Further sequences latch one target and then change the fields, to show that reads follow the latched block.

// File: rtl/acc_perm_pkg.sv
package acc_perm_pkg;

    typedef enum logic [1:0] {
        NP_NONE = 2'd0,
        NP_DATA = 2'd1,
        NP_RSEL = 2'd2
    } nack_pt_e;

    localparam logic [1:0] FLD_RW     = 2'b11;
    localparam int         SIDE_OFS_W = 5;
    localparam logic [4:0] SIDE_FIXED_LAST = 5'd8;
    localparam logic [4:0] SIDE_RO_A  = 5'd14;
    localparam logic [4:0] SIDE_RO_B  = 5'd15;

endpackage

// File: rtl/acc_main_perm.sv
module acc_main_perm
    import acc_perm_pkg::*;
#(
    parameter int NUM_BLOCKS  = 8,
    parameter int BLOCK_BYTES = 128,
    parameter int PAGE_BYTES  = 16
) (
    input  logic [$clog2(NUM_BLOCKS)+$clog2(BLOCK_BYTES/PAGE_BYTES)-1:0] blkpg,
    input  logic                                     wp,
    input  logic [2*NUM_BLOCKS-1:0]                  blk_fields,
    input  logic [BLOCK_BYTES/PAGE_BYTES-1:0]        b0_page_wen,
    output logic                                     rd_ok,
    output logic                                     wr_ok
);
    localparam int BLK_W      = $clog2(NUM_BLOCKS);
    localparam int PG_PER_BLK = BLOCK_BYTES / PAGE_BYTES;
    localparam int PG_W       = $clog2(PG_PER_BLK);

    logic [BLK_W-1:0]      blk;
    logic [PG_W-1:0]       page;
    logic [1:0]            fld     [NUM_BLOCKS];
    logic [NUM_BLOCKS-1:0] blk_rd;
    logic [NUM_BLOCKS-1:0] blk_wr;

    assign blk  = blkpg[BLK_W+PG_W-1 -: BLK_W];
    assign page = blkpg[PG_W-1:0];

    // Per-block decode; only block 0 carries page-level write gating.
    for (genvar g = 0; g < NUM_BLOCKS; g++) begin : g_blk
        assign fld[g]    = blk_fields[2*g +: 2];
        assign blk_rd[g] = fld[g][1];
        if (g == 0) begin : g_paged
            assign blk_wr[g] = (fld[g] == FLD_RW) && b0_page_wen[page];
        end else begin : g_plain
            assign blk_wr[g] = (fld[g] == FLD_RW);
        end
    end

    assign rd_ok = blk_rd[blk];
    assign wr_ok = !wp && blk_wr[blk];

endmodule

// File: rtl/acc_side_perm.sv
module acc_side_perm
    import acc_perm_pkg::*;
(
    input  logic [SIDE_OFS_W-1:0] ofs,
    input  logic                  wp,
    input  logic [1:0]            side_field,
    output logic                  rd_ok,
    output logic                  wr_ok,
    output logic                  wr_store
);
    logic fixed_byte;
    logic ro_byte;

    assign fixed_byte = (ofs <= SIDE_FIXED_LAST);
    assign ro_byte    = (ofs == SIDE_RO_A) || (ofs == SIDE_RO_B);

    always_comb begin
        rd_ok    = fixed_byte || side_field[1];
        wr_ok    = !wp && (fixed_byte || (side_field == FLD_RW));
        wr_store = wr_ok && !ro_byte;
    end

endmodule

// File: rtl/acc_perm_chk.sv
module acc_perm_chk
    import acc_perm_pkg::*;
#(
    parameter int NUM_BLOCKS  = 8,
    parameter int BLOCK_BYTES = 128,
    parameter int PAGE_BYTES  = 16,
    localparam int PG_PER_BLK = BLOCK_BYTES / PAGE_BYTES,
    localparam int ADDR_W     = $clog2(NUM_BLOCKS * BLOCK_BYTES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    evt_valid,
    input  logic                    evt_read,
    input  logic                    tgt_side,
    input  logic [ADDR_W-1:0]       tgt_addr,
    input  logic                    wp,
    input  logic [2*NUM_BLOCKS-1:0] blk_fields,
    input  logic [1:0]              side_field,
    input  logic [PG_PER_BLK-1:0]   b0_page_wen,
    output logic                    dec_valid,
    output logic                    dec_permit,
    output logic [1:0]              dec_nack_pt,
    output logic                    dec_wr_go
);
    localparam int BYTE_W = $clog2(PAGE_BYTES);

    typedef struct packed {
        logic              side;
        logic [ADDR_W-1:0] addr;
        logic              dv;
        logic              permit;
        nack_pt_e          nack;
        logic              go;
    } st_t;

    st_t st_d, st_q;

    logic              sel_side;
    logic [ADDR_W-1:0] sel_addr;
    logic              m_rd, m_wr;
    logic              s_rd, s_wr, s_store;
    logic              ok_c;

    // Reads judge the latched target; write events judge their own.
    assign sel_side = evt_read ? st_q.side : tgt_side;
    assign sel_addr = evt_read ? st_q.addr : tgt_addr;

    acc_main_perm #(
        .NUM_BLOCKS  (NUM_BLOCKS),
        .BLOCK_BYTES (BLOCK_BYTES),
        .PAGE_BYTES  (PAGE_BYTES)
    ) u_main (
        .blkpg       (sel_addr[ADDR_W-1:BYTE_W]),
        .wp          (wp),
        .blk_fields  (blk_fields),
        .b0_page_wen (b0_page_wen),
        .rd_ok       (m_rd),
        .wr_ok       (m_wr)
    );

    acc_side_perm u_side (
        .ofs        (sel_addr[SIDE_OFS_W-1:0]),
        .wp         (wp),
        .side_field (side_field),
        .rd_ok      (s_rd),
        .wr_ok      (s_wr),
        .wr_store   (s_store)
    );

    always_comb begin
        st_d    = st_q;
        st_d.dv = 1'b0;
        ok_c    = 1'b0;
        if (evt_valid) begin
            st_d.dv = 1'b1;
            if (evt_read) begin
                ok_c        = sel_side ? s_rd : m_rd;
                st_d.permit = ok_c;
                st_d.nack   = ok_c ? NP_NONE : NP_RSEL;
                st_d.go     = 1'b0;
            end else begin
                ok_c        = sel_side ? s_wr : m_wr;
                st_d.side   = tgt_side;
                st_d.addr   = tgt_addr;
                st_d.permit = ok_c;
                st_d.nack   = ok_c ? NP_NONE : NP_DATA;
                st_d.go     = ok_c && (sel_side ? s_store : 1'b1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{side: 1'b0, addr: '0, dv: 1'b0, permit: 1'b0,
                      nack: NP_NONE, go: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign dec_valid   = st_q.dv;
    assign dec_permit  = st_q.permit;
    assign dec_nack_pt = st_q.nack;
    assign dec_wr_go   = st_q.go;

    AST_DECISION_NEXT_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |=> dec_valid); // R1
    AST_NO_SPURIOUS_DECISION: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_valid |=> (!dec_valid && $stable(dec_permit) && $stable(dec_wr_go))); // R1
    AST_WP_REFUSES_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && !evt_read && wp) |=>
            (!dec_permit && dec_nack_pt == NP_DATA && !dec_wr_go)); // R5
    AST_READ_NEVER_GOES: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_read) |=> (!dec_wr_go && dec_nack_pt != NP_DATA)); // R11
    AST_FIXED_SIDE_READABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_read && st_q.side &&
         st_q.addr[SIDE_OFS_W-1:0] <= SIDE_FIXED_LAST) |=> dec_permit); // R7
    AST_GO_NEEDS_PERMIT: assert property (@(posedge clk) disable iff (!rst_n)
        dec_wr_go |-> (dec_permit && dec_nack_pt == NP_NONE)); // R11

endmodule

// File: tb/tb_acc_perm_chk.sv
module tb_acc_perm_chk;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        evt_valid, evt_read, tgt_side, wp;
    logic [9:0]  tgt_addr;
    logic [15:0] blk_fields;
    logic [1:0]  side_field;
    logic [7:0]  b0_page_wen;
    logic        dec_valid, dec_permit, dec_wr_go;
    logic [1:0]  dec_nack_pt;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    acc_perm_chk dut (
        .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_read(evt_read),
        .tgt_side(tgt_side), .tgt_addr(tgt_addr), .wp(wp),
        .blk_fields(blk_fields), .side_field(side_field),
        .b0_page_wen(b0_page_wen), .dec_valid(dec_valid),
        .dec_permit(dec_permit), .dec_nack_pt(dec_nack_pt), .dec_wr_go(dec_wr_go)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Drives one event at a falling edge; outputs are sampled at the next falling edge.
    task automatic evt(input logic rd, input logic side, input logic [9:0] a);
        @(negedge clk);
        evt_valid = 1'b1; evt_read = rd; tgt_side = side; tgt_addr = a;
        @(negedge clk);
        evt_valid = 1'b0;
    endtask

    task automatic expect_dec(input string tag, input int p, input int n, input int g);
        chk({tag, " dec_valid"}, dec_valid, 1);
        chk({tag, " permit"},    dec_permit, p);
        chk({tag, " nack_pt"},   dec_nack_pt, n);
        chk({tag, " wr_go"},     dec_wr_go, g);
    endtask

    task automatic set_field(input int b, input logic [1:0] v);
        blk_fields[2*b +: 2] = v;
    endtask

    task automatic t_reset();
        blk_fields = 16'hFFFC; // block 0 field 00
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R10 valid in reset", dec_valid, 0);
        chk("R10 permit in reset", dec_permit, 0);
        chk("R10 nack in reset", dec_nack_pt, 0);
        chk("R10 go in reset", dec_wr_go, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 valid after reset", dec_valid, 0);
        evt(1'b1, 1'b0, 10'h3FF);
        expect_dec("R6 read after reset uses block 0", 0, 2, 0);
        blk_fields = 16'hFFFF;
    endtask

    task automatic t_basic();
        evt(1'b0, 1'b0, {3'd3, 3'd2, 4'd7});
        expect_dec("R11 write permitted", 1, 0, 1);
        evt(1'b1, 1'b0, 10'd0);
        expect_dec("R11 read permitted", 1, 0, 0);
        @(negedge clk);
        chk("R1 valid is one cycle", dec_valid, 0);
        chk("R1 permit holds", dec_permit, 1);
    endtask

    task automatic t_encodings();
        for (int e = 0; e < 4; e++) begin
            set_field(5, e[1:0]);
            evt(1'b0, 1'b0, {3'd5, 3'd1, 4'd0});
            expect_dec($sformatf("R3 write enc %0d", e), (e == 3) ? 1 : 0,
                       (e == 3) ? 0 : 1, (e == 3) ? 1 : 0);
            evt(1'b1, 1'b0, 10'd0);
            expect_dec($sformatf("R2 read enc %0d", e), (e >= 2) ? 1 : 0,
                       (e >= 2) ? 0 : 2, 0);
        end
        blk_fields = 16'hFFFF;
    endtask

    task automatic t_block0_pages();
        logic [7:0] m;
        m = 8'b1010_0110;
        b0_page_wen = m;
        for (int p = 0; p < 8; p++) begin
            evt(1'b0, 1'b0, {3'd0, p[2:0], 4'd5});
            expect_dec($sformatf("R4 block0 page %0d", p), m[p], m[p] ? 0 : 1, m[p]);
        end
        b0_page_wen = 8'hFF;
        set_field(0, 2'b10);
        evt(1'b0, 1'b0, {3'd0, 3'd3, 4'd15});
        expect_dec("R4 page enabled but field 10", 0, 1, 0);
        set_field(0, 2'b11);
        b0_page_wen = 8'h00;
        evt(1'b0, 1'b0, {3'd1, 3'd0, 4'd0});
        expect_dec("R3 block 1 ignores page enables", 1, 0, 1);
        evt(1'b0, 1'b0, {3'd7, 3'd7, 4'd15});
        expect_dec("R3 block 7 ignores page enables", 1, 0, 1);
        b0_page_wen = 8'hFF;
    endtask

    task automatic t_wp();
        wp = 1'b1;
        side_field = 2'b11;
        evt(1'b0, 1'b0, {3'd2, 3'd0, 4'd0});
        expect_dec("R5 wp main write", 0, 1, 0);
        evt(1'b0, 1'b1, 10'd3);
        expect_dec("R5 wp protection byte 3", 0, 1, 0);
        evt(1'b0, 1'b1, 10'd20);
        expect_dec("R5 wp id byte", 0, 1, 0);
        evt(1'b0, 1'b0, {3'd4, 3'd0, 4'd0});
        evt(1'b1, 1'b0, 10'd0);
        expect_dec("R5 wp leaves reads", 1, 0, 0);
        wp = 1'b0;
    endtask

    task automatic t_latched();
        evt(1'b0, 1'b0, {3'd2, 3'd0, 4'd1});
        expect_dec("R6 latch write", 1, 0, 1);
        set_field(2, 2'b00);
        evt(1'b1, 1'b0, {3'd6, 3'd0, 4'd0});
        expect_dec("R6 read uses latched block 2", 0, 2, 0);
        set_field(2, 2'b11);
        set_field(6, 2'b01);
        evt(1'b1, 1'b0, {3'd2, 3'd0, 4'd0});
        expect_dec("R6 read select bits ignored", 1, 0, 0);
        evt(1'b0, 1'b0, {3'd6, 3'd0, 4'd0});
        expect_dec("R3 refused write to block 6", 0, 1, 0);
        evt(1'b1, 1'b0, {3'd2, 3'd0, 4'd0});
        expect_dec("R6 refused write still latches", 0, 2, 0);
        blk_fields = 16'hFFFF;
    endtask

    task automatic t_side();
        side_field = 2'b00;
        evt(1'b0, 1'b1, 10'd4);
        evt(1'b1, 1'b0, 10'd0);
        expect_dec("R7 prot byte 4 readable", 1, 0, 0);
        evt(1'b0, 1'b1, 10'd8);
        expect_dec("R7 prot byte 8 writable", 1, 0, 1);
        evt(1'b1, 1'b0, 10'd0);
        expect_dec("R7 prot byte 8 readable", 1, 0, 0);
        evt(1'b0, 1'b1, 10'd9);
        expect_dec("R8 prot byte 9 write field 00", 0, 1, 0);
        evt(1'b1, 1'b0, 10'd0);
        expect_dec("R8 prot byte 9 read field 00", 0, 2, 0);
        evt(1'b0, 1'b1, 10'd16);
        evt(1'b1, 1'b0, 10'd0);
        expect_dec("R8 id byte 16 read field 00", 0, 2, 0);
        side_field = 2'b10;
        evt(1'b0, 1'b1, 10'd25);
        expect_dec("R8 id byte 25 write field 10", 0, 1, 0);
        evt(1'b1, 1'b0, 10'd0);
        expect_dec("R8 id byte 25 read field 10", 1, 0, 0);
        side_field = 2'b11;
        evt(1'b0, 1'b1, 10'd31);
        expect_dec("R8 id byte 31 write field 11", 1, 0, 1);
        evt(1'b0, 1'b1, 10'd13);
        expect_dec("R8 prot byte 13 write field 11", 1, 0, 1);
        evt(1'b0, 1'b1, 10'd14);
        expect_dec("R9 byte 14 acked without cycle", 1, 0, 0);
        evt(1'b0, 1'b1, 10'd15);
        expect_dec("R9 byte 15 acked without cycle", 1, 0, 0);
        evt(1'b1, 1'b0, 10'd0);
        expect_dec("R9 byte 15 readable", 1, 0, 0);
    endtask

    initial begin
        evt_valid = 1'b0; evt_read = 1'b0; tgt_side = 1'b0; tgt_addr = '0;
        wp = 1'b0; side_field = 2'b11; b0_page_wen = 8'hFF;
        blk_fields = 16'hFFFF; rst_n = 1'b0;
        t_reset();
        t_basic();
        t_encodings();
        t_block0_pages();
        t_wp();
        t_latched();
        t_side();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule